// File: doc/BRIEF.md
# Single-wire identity code CRC checker

This block receives the 64-bit identity code of a single-wire bus device as a stream of already-sampled bits. Each bit comes with a valid strobe, and the least significant bit of byte 0 arrives first. Every accepted bit passes through an 8-bit CRC shift register whose generator is x^8 + x^5 + x^4 + 1, shifted right in reflected form.

The code holds 56 payload bits followed by the stored check byte. When the whole code has gone through, an intact code leaves the register at zero. The block then raises a one-cycle completion pulse together with a pass flag; a nonzero residue clears the flag, which tells the host to read the code again. On the way through, the block keeps the low byte (the family code) and the following six bytes (the serial number). A host pulses `start` before each read. The running CRC is exposed so the 56-bit checksum can be observed mid-stream.

Top module: `idcode_crc_check`

## Requirements
- R1: Reset or a `start` pulse clears the CRC register, `family` and `serial` to zero, drives `done` and `code_ok` low, and arms the block to accept a new code.
- R2: Each accepted bit updates the CRC in LSB-first reflected form: feedback = bit XOR crc[0]; crc shifts right; when feedback is 1 the register is XORed with 0x8C. After the bytes 02,1C,B8,01,00,00,00 (byte 0 first, each byte LSB first), `crc_run` reads 0xA2.
- R3: The 64th accepted bit after arming produces `done` high for exactly one cycle, starting with the clock edge that samples that bit.
- R4: At `done`, `code_ok` is 1 when the 64-bit residue is 0x00 and 0 for any nonzero residue, including any single-bit corruption of a valid code.
- R5: `family` holds accepted bits 0..7 and `serial` holds accepted bits 8..55, the earliest bit in each field's LSB. Both are complete at `done`.
- R6: Bits strobed after `done` and before the next `start` are ignored: `crc_run`, `family`, `serial` and `code_ok` are unchanged and no further `done` appears.
- R7: `code_ok` changes only at `done` or on a `start` or reset; between `done` and the next `start` it is held.
- R8: `start` takes priority over a strobe in the same cycle, so that bit is dropped. A `start` in the middle of a code discards the partial code.
- R9: After 56 payload bits, feeding the ones' complement of `crc_run` as the last 8 bits leaves a residue of 0x35 and `code_ok` at 0.
- R10: In cycles with `bit_vld` low, the CRC, the fields and the bit count do not change, so gaps of any length between bits do not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clear and arm for a new code |
| bit_vld | input | 1 | Strobe: `bit_in` holds a sampled bit |
| bit_in | input | 1 | Serial code bit, LSB of byte 0 first |
| done | output | 1 | One-cycle pulse after the 64th bit |
| code_ok | output | 1 | 1 = zero residue, 0 = read again |
| crc_run | output | 8 | Running CRC register |
| family | output | 8 | Captured byte 0 |
| serial | output | 48 | Captured bytes 1..6 |

## Verification
The assertions assume that `start` and `rst` are the only ways to rearm the block, and that `bit_vld` and `bit_in` are clean levels at each clock edge. The bench drives both away from the edge and never lets a strobe overlap a start except in the one test that checks priority. The sweeps cover every family code with a correct check byte. They also cover a single-bit corruption that walks across all 64 positions, and strobe gaps of several lengths. Expected checksums are worked out in the bench by polynomial division over the whole code.

// File: rtl/idcode_crc_pkg.sv
package idcode_crc_pkg;

    localparam int          CRC_W      = 8;
    localparam logic [7:0]  CRC_POLY_R = 8'h8C;  // x^8+x^5+x^4+1, reflected
    localparam int          CODE_BITS  = 64;
    localparam int          FAM_BITS   = 8;
    localparam int          SER_BITS   = 48;

    // per-bit control produced by the sequencer
    typedef struct packed {
        logic take;   // bit accepted this cycle
        logic last;   // accepted bit is the final one of the code
        logic clear;  // rearm request
    } seq_ctl_t;

    function automatic logic feedback_bit(input logic lsb, input logic din);
        return lsb ^ din;
    endfunction

endpackage

// File: rtl/idcode_bit_seq.sv
module idcode_bit_seq
    import idcode_crc_pkg::*;
#(
    parameter int NBITS = CODE_BITS,
    localparam int CW   = $clog2(NBITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          bit_vld,
    output seq_ctl_t      ctl,
    output logic [CW-1:0] count,
    output logic          armed
);

    logic [CW-1:0] cnt_q;
    logic          armed_q;

    always_comb begin
        ctl.clear = start;
        ctl.take  = armed_q && bit_vld && !start;
        ctl.last  = ctl.take && (cnt_q == CW'(NBITS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (ctl.take) begin
            cnt_q <= cnt_q + 1'b1;
            if (ctl.last) armed_q <= 1'b0;
        end
    end

    assign count = cnt_q;
    assign armed = armed_q;

    // R6
    idle_count_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !armed_q |-> cnt_q == '0);

    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_vld && !start) |=> $stable(cnt_q));

endmodule

// File: rtl/idcode_crc_lfsr.sv
module idcode_crc_lfsr
    import idcode_crc_pkg::*;
#(
    parameter int          W    = CRC_W,
    parameter logic [W-1:0] POLY = CRC_POLY_R
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         take,
    input  logic         din,
    output logic [W-1:0] crc,
    output logic [W-1:0] crc_next
);

    logic [W-1:0] crc_q;
    logic [W-1:0] stepped;
    logic         fb;

    assign fb = feedback_bit(crc_q[0], din);

    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == W - 1) begin : g_msb
            assign stepped[i] = POLY[i] & fb;
        end else begin : g_low
            assign stepped[i] = crc_q[i+1] ^ (POLY[i] & fb);
        end
    end

    assign crc_next = take ? stepped : crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) crc_q <= '0;
        else              crc_q <= crc_next;
    end

    assign crc = crc_q;

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> crc_q == '0);

    // R10
    crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!take && !clear) |=> $stable(crc_q));

endmodule

// File: rtl/idcode_field_cap.sv
module idcode_field_cap
    import idcode_crc_pkg::*;
#(
    parameter int NBITS = CODE_BITS,
    parameter int FAM_W = FAM_BITS,
    parameter int SER_W = SER_BITS,
    localparam int CAP_W = FAM_W + SER_W,
    localparam int CW    = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             take,
    input  logic [CW-1:0]    count,
    input  logic             din,
    output logic [FAM_W-1:0] family,
    output logic [SER_W-1:0] serial
);

    logic [CAP_W-1:0] cap_q;
    logic             in_payload;

    assign in_payload = count < CW'(CAP_W);

    always_ff @(posedge clk) begin
        if (rst || clear)              cap_q <= '0;
        else if (take && in_payload)   cap_q <= {din, cap_q[CAP_W-1:1]};
    end

    assign family = cap_q[FAM_W-1:0];
    assign serial = cap_q[CAP_W-1:FAM_W];

    // R5
    cap_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_payload && !clear) |=> $stable(cap_q));

endmodule

// File: rtl/idcode_crc_check.sv
module idcode_crc_check
    import idcode_crc_pkg::*;
#(
    parameter int NBITS = CODE_BITS,
    parameter int FAM_W = FAM_BITS,
    parameter int SER_W = SER_BITS,
    parameter int W     = CRC_W,
    parameter logic [W-1:0] POLY = CRC_POLY_R,
    localparam int CW   = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic             done,
    output logic             code_ok,
    output logic [W-1:0]     crc_run,
    output logic [FAM_W-1:0] family,
    output logic [SER_W-1:0] serial
);

    seq_ctl_t      ctl;
    logic [CW-1:0] count;
    logic          armed;
    logic [W-1:0]  crc_next;
    logic          done_q;
    logic          ok_q;

    idcode_bit_seq #(.NBITS(NBITS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .bit_vld (bit_vld),
        .ctl     (ctl),
        .count   (count),
        .armed   (armed)
    );

    idcode_crc_lfsr #(.W(W), .POLY(POLY)) u_lfsr (
        .clk      (clk),
        .rst      (rst),
        .clear    (ctl.clear),
        .take     (ctl.take),
        .din      (bit_in),
        .crc      (crc_run),
        .crc_next (crc_next)
    );

    idcode_field_cap #(.NBITS(NBITS), .FAM_W(FAM_W), .SER_W(SER_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .clear  (ctl.clear),
        .take   (ctl.take),
        .count  (count),
        .din    (bit_in),
        .family (family),
        .serial (serial)
    );

    always_ff @(posedge clk) begin
        if (rst || start) begin
            done_q <= 1'b0;
            ok_q   <= 1'b0;
        end else begin
            done_q <= ctl.last;
            if (ctl.last) ok_q <= (crc_next == '0);
        end
    end

    assign done    = done_q;
    assign code_ok = ok_q;

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R4
    ok_residue_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (ok_q == (crc_run == '0)));

    // R7
    ok_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ok_q) |-> (done_q || $past(start)));

    // R6
    after_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed && !start) |=> ($stable(crc_run) && !done_q));

endmodule

// File: tb/tb_idcode_crc_check.sv
module tb_idcode_crc_check;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic        done;
    logic        code_ok;
    logic [7:0]  crc_run;
    logic [7:0]  family;
    logic [47:0] serial;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    idcode_crc_check dut (
        .clk(clk), .rst(rst), .start(start), .bit_vld(bit_vld), .bit_in(bit_in),
        .done(done), .code_ok(code_ok), .crc_run(crc_run),
        .family(family), .serial(serial)
    );

    task automatic check(input logic cond, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // remainder of (msg * x^8) mod g, computed on reversed bit order:
    // the reflected checksum of a bit stream sent LSB first
    function automatic logic [7:0] ref_crc(input logic [63:0] msg, input int n);
        logic [8:0] rem = '0;
        logic [7:0] out;
        for (int i = 0; i < n + 8; i++) begin
            rem = {rem[7:0], (i < n) ? msg[i] : 1'b0};
            if (rem[8]) rem = rem ^ 9'h131;
        end
        for (int k = 0; k < 8; k++) out[k] = rem[7-k];
        return out;
    endfunction

    function automatic logic [63:0] make_code(input logic [7:0] fam, input logic [47:0] ser);
        logic [55:0] pay = {ser, fam};
        return {ref_crc({8'h00, pay}, 56), pay};
    endfunction

    task automatic drive_bit(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
    endtask

    task automatic idle();
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk);
        bit_vld = 1'b0;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
    endtask

    // sends bits [lo,hi) of code; gap>0 inserts idle cycles
    task automatic send_bits(input logic [63:0] code, input int lo, input int hi, input int gap);
        for (int i = lo; i < hi; i++) begin
            drive_bit(code[i]);
            if (gap > 0 && (i % gap) == 0 && i != hi - 1) idle();
        end
        idle();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [63:0] code;
        logic [7:0]  mid;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(done == 1'b0, "R1 done after reset", 64'(done), 0);
        check(code_ok == 1'b0, "R1 ok after reset", 64'(code_ok), 0);
        check(crc_run == 8'h00, "R1 crc after reset", 64'(crc_run), 0);
        check(family == 8'h00 && serial == 48'h0, "R1 fields after reset",
              {8'h0, serial, family} , 0);

        // R2 known payload gives A2, R4 and R5 with the A2 check byte
        code = {8'hA2, 48'h000001B81C, 8'h02};
        do_start();
        send_bits(code, 0, 56, 0);
        check(crc_run == 8'hA2, "R2 crc after 56 bits", 64'(crc_run), 64'hA2);
        check(ref_crc(code, 56) == 8'hA2, "R2 bench model", 64'(ref_crc(code, 56)), 64'hA2);
        send_bits(code, 56, 64, 0);
        check(done == 1'b1, "R3 done after bit 64", 64'(done), 1);
        check(code_ok == 1'b1, "R4 ok known code", 64'(code_ok), 1);
        check(crc_run == 8'h00, "R4 zero residue", 64'(crc_run), 0);
        check(family == 8'h02, "R5 family", 64'(family), 64'h02);
        check(serial == 48'h000001B81C, "R5 serial", 64'(serial), 64'h1B81C);
        @(negedge clk);
        check(done == 1'b0, "R3 done one cycle", 64'(done), 0);
        check(code_ok == 1'b1, "R7 ok held", 64'(code_ok), 1);

        // R6 bits after done ignored
        for (int i = 0; i < 12; i++) begin
            drive_bit(i[0] ^ i[2]);
        end
        idle();
        check(done == 1'b0, "R6 no done", 64'(done), 0);
        check(crc_run == 8'h00, "R6 crc unchanged", 64'(crc_run), 0);
        check(family == 8'h02 && serial == 48'h000001B81C, "R6 fields unchanged",
              {8'h0, serial, family}, {8'h0, 48'h000001B81C, 8'h02});
        check(code_ok == 1'b1, "R6 R7 ok unchanged", 64'(code_ok), 1);

        // sweep every family code with correct check byte, varying gaps
        for (int v = 0; v < 256; v++) begin
            logic [47:0] ser = {8'(v ^ 8'h5A), 8'(v * 3), 8'(~v), 8'(v + 17), 8'(v * 11), 8'(v ^ 8'hC3)};
            code = make_code(8'(v), ser);
            do_start();
            check(code_ok == 1'b0, "R1 ok cleared by start", 64'(code_ok), 0);
            send_bits(code, 0, 64, v % 5);
            check(done == 1'b1, "R3 R10 done with gaps", 64'(done), 1);
            check(code_ok == 1'b1, "R4 ok good code", 64'(code_ok), 1);
            check(family == 8'(v) && serial == ser, "R5 fields sweep",
                  {8'h0, serial, family}, {8'h0, ser, 8'(v)});
        end

        // single-bit corruption walking all 64 positions
        for (int v = 0; v < 256; v++) begin
            int pos = (v * 7 + 3) % 64;
            code = make_code(8'(v), {8'(v), 8'(v * 5), 8'h33, 8'(v + 1), 8'h0F, 8'(~v)});
            code[pos] = ~code[pos];
            do_start();
            send_bits(code, 0, 64, v % 3);
            check(done == 1'b1, "R3 done bad code", 64'(done), 1);
            check(code_ok == 1'b0, "R4 corrupt bit rejected", 64'(code_ok), 0);
            check(crc_run != 8'h00, "R4 nonzero residue", 64'(crc_run), 64'hFF);
        end

        // R9 complement property
        for (int v = 0; v < 16; v++) begin
            code = make_code(8'(v * 16 + 1), {6{8'(v)}});
            do_start();
            send_bits(code, 0, 56, 0);
            mid = ref_crc(code, 56);
            check(crc_run == mid, "R2 running crc", 64'(crc_run), 64'(mid));
            code[63:56] = ~mid;
            send_bits(code, 56, 64, 0);
            check(crc_run == 8'h35, "R9 complement residue", 64'(crc_run), 64'h35);
            check(code_ok == 1'b0, "R9 ok low", 64'(code_ok), 0);
        end

        // R8 restart mid-code, then start together with a strobe
        code = make_code(8'h28, 48'h123456789ABC);
        do_start();
        send_bits(~code, 0, 20, 0);
        do_start();
        check(crc_run == 8'h00 && family == 8'h00, "R8 partial discarded",
              {48'h0, crc_run, family}, 0);
        @(negedge clk);
        start   = 1'b1;
        bit_vld = 1'b1;
        bit_in  = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        bit_vld = 1'b0;
        check(crc_run == 8'h00, "R8 start wins crc", 64'(crc_run), 0);
        check(family == 8'h00, "R8 start wins field", 64'(family), 0);
        send_bits(code, 0, 64, 4);
        check(done == 1'b1 && code_ok == 1'b1, "R8 code after restart",
              {62'h0, done, code_ok}, 64'h3);
        check(family == 8'h28 && serial == 48'h123456789ABC, "R8 R5 fields after restart",
              {8'h0, serial, family}, {8'h0, 48'h123456789ABC, 8'h28});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule